// File: doc/BRIEF.md
# Calendar Time Counter

This block holds wall-clock time and calendar date as seven byte-wide fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Every pulse on the one-second tick input moves the time forward by exactly one second. Carries ripple from seconds through minutes and hours into the day fields, then into month and year. The day-of-month rollover follows each month's length and the leap-year rule.

A mode input chooses how every field is encoded. In decimal-digit (BCD) mode the tens digit sits in bits 7:4 and the units digit in bits 3:0. In plain binary mode the field holds its value directly. A host loads any one field through a single-cycle write port. An inhibit input holds the time still while the host rewrites several fields. Hours always use 24-hour format. The two-digit year is read in the window 1950 to 2049, and inside that window a year is a leap year exactly when its two-digit value is divisible by 4.

A one-cycle carry output marks each rollover of seconds from 59 to 00, so the next stage counting minutes can follow it.

Top module: `calendar_clock`

## Requirements
- R1: After reset the fields read 00 seconds, 00 minutes, 00 hours, day of week 7, day of month 1, month 1, year 00, and the carry output is low.
- R2: Each tick with inhibit low and no write adds one second. In BCD mode the seconds tens digit is in bits 7:4 and the units digit is in bits 3:0. Seconds go from 59 to 00. In the cycle where the fields show that rollover, the carry output is high for exactly that one cycle and is low after every other tick.
- R3: Minutes go from 59 to 00 and add one to hours. Hours go from 23 to 00, so the hours field always reads 0 to 23.
- R4: The day-of-week field (1 = Sunday) holds 1 to 7. It adds one at each midnight and goes from 7 back to 1.
- R5: At midnight the day of month goes back to 1 once it has reached the length of the current month: 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. Below that length it adds one.
- R6: February has 29 days when the two-digit year is divisible by 4, and 28 days otherwise. This matches the 1950 to 2049 window.
- R7: The month field holds 1 to 12. Month 12 rolls over to 1 and adds one to the year. The year goes from 99 to 00.
- R8: While inhibit is high, ticks are dropped and no field changes.
- R9: When write enable is high, the field picked by the select input takes the write data on the next edge. The select codes are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. A tick in the same cycle as a write is dropped. Writes still work while inhibit is high.
- R10: With the binary mode input high, every field counts and rolls over in plain binary with the same limits. For example, seconds read 0x3B before they return to 0x00.
- R11: A write with select code 7 changes no field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| inhibit | input | 1 | High holds the time still; ticks are dropped |
| binMode | input | 1 | 1 = plain binary fields, 0 = BCD digit fields |
| wrEn | input | 1 | Host field write strobe |
| wrSel | input | 3 | Field select for the write (codes given in R9) |
| wrData | input | 8 | Value to load, encoded for the current mode |
| seconds | output | 8 | Seconds field |
| minutes | output | 8 | Minutes field |
| hours | output | 8 | Hours field, 24-hour |
| weekDay | output | 8 | Day of week, 1 = Sunday |
| monthDay | output | 8 | Day of month |
| month | output | 8 | Month, 1 to 12 |
| year | output | 8 | Year modulo 100 |
| secCarry | output | 1 | One-cycle pulse at each rollover of seconds |

## Verification
The range and digit-validity properties hold only under three conditions. The host must write values that are legal for the field and encoded for the current mode. The binary mode input must change only while reset is held. The day-of-month field must never be written beyond the length of the current month. The stimulus meets all three. It encodes every value it writes with the active mode, switches mode only while reset is asserted, and builds each calendar case from dates that exist, such as the last day of each month or day 28. Under these conditions, every rollover the counter makes on its own produces legal digits.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FIELD_W   = 8;
  localparam int SEL_W     = 3;
  localparam logic [FIELD_W-1:0] SEC_LAST   = 8'd59;
  localparam logic [FIELD_W-1:0] MIN_LAST   = 8'd59;
  localparam logic [FIELD_W-1:0] HOUR_LAST  = 8'd23;
  localparam logic [FIELD_W-1:0] WDAY_LAST  = 8'd7;
  localparam logic [FIELD_W-1:0] MONTH_LAST = 8'd12;
  localparam logic [FIELD_W-1:0] YEAR_LAST  = 8'd99;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_WDAY  = 3'd3,
    FLD_MDAY  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_NONE  = 3'd7
  } fieldSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      incSec;
    logic      incMin;
    logic      incHour;
    logic      incDay;
    logic      incMonth;
    logic      incYear;
    logic      load;
    fieldSel_e loadSel;
  } calStrobe_t;

  // last-value flags from datapath to control
  typedef struct packed {
    logic secLast;
    logic minLast;
    logic hourLast;
    logic mdayLast;
    logic monthLast;
  } calWrap_t;

  function automatic logic [FIELD_W-1:0] encodeField(input logic [FIELD_W-1:0] v,
                                                     input logic bin);
    logic [FIELD_W-1:0] tens;
    logic [FIELD_W-1:0] units;
    tens  = v / 8'd10;
    units = v % 8'd10;
    return bin ? v : {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [FIELD_W-1:0] decodeField(input logic [FIELD_W-1:0] v,
                                                     input logic bin);
    return bin ? v : ({4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]});
  endfunction

  function automatic logic [FIELD_W-1:0] stepField(input logic [FIELD_W-1:0] v,
                                                   input logic bin);
    if (bin) return v + 8'd1;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // month and year in binary; year in the 1950..2049 window
  function automatic logic [FIELD_W-1:0] monthLength(input logic [FIELD_W-1:0] mon,
                                                     input logic [FIELD_W-1:0] yr);
    case (mon)
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_field.sv
module cal_field
  import cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RST_VAL  = '0,
  parameter logic [FIELD_W-1:0] WRAP_VAL = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               binMode,
  input  logic               inc,
  input  logic               load,
  input  logic [FIELD_W-1:0] loadData,
  input  logic [FIELD_W-1:0] lastVal,
  output logic               atLast,
  output logic [FIELD_W-1:0] val
);
  logic [FIELD_W-1:0] wrapEnc;

  assign wrapEnc = encodeField(WRAP_VAL, binMode);
  assign atLast  = (val == encodeField(lastVal, binMode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     val <= RST_VAL;
    else if (load) val <= loadData;
    else if (inc)  val <= atLast ? wrapEnc : stepField(val, binMode);
  end
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             inhibit,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  calWrap_t         wrap,
  output calStrobe_t       strobe,
  output logic             secCarry
);
  logic advance;

  // a host write wins over a tick in the same cycle
  assign advance = tick && !inhibit && !wrEn;

  always_comb begin
    strobe.incSec   = advance;
    strobe.incMin   = strobe.incSec   && wrap.secLast;
    strobe.incHour  = strobe.incMin   && wrap.minLast;
    strobe.incDay   = strobe.incHour  && wrap.hourLast;
    strobe.incMonth = strobe.incDay   && wrap.mdayLast;
    strobe.incYear  = strobe.incMonth && wrap.monthLast;
    strobe.load     = wrEn;
    strobe.loadSel  = fieldSel_e'(wrSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) secCarry <= 1'b0;
    else       secCarry <= strobe.incMin;
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RST_WDAY  = 8'd7,
  parameter logic [FIELD_W-1:0] RST_MDAY  = 8'd1,
  parameter logic [FIELD_W-1:0] RST_MONTH = 8'd1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               binMode,
  input  calStrobe_t         strobe,
  input  logic [FIELD_W-1:0] wrData,
  output calWrap_t           wrap,
  output logic [FIELD_W-1:0] seconds,
  output logic [FIELD_W-1:0] minutes,
  output logic [FIELD_W-1:0] hours,
  output logic [FIELD_W-1:0] weekDay,
  output logic [FIELD_W-1:0] monthDay,
  output logic [FIELD_W-1:0] month,
  output logic [FIELD_W-1:0] year
);
  logic [FIELD_W-1:0] daysNow;
  logic               wdayLast;
  logic               yearLast;
  logic [6:0]         ld;

  assign daysNow = monthLength(decodeField(month, binMode), decodeField(year, binMode));

  for (genvar f = 0; f < 7; f++) begin : g_ld
    assign ld[f] = strobe.load && (strobe.loadSel == fieldSel_e'(f));
  end

  cal_field #(.RST_VAL(8'd0), .WRAP_VAL(8'd0)) u_sec (
    .clk, .rstN, .binMode, .inc(strobe.incSec), .load(ld[FLD_SEC]), .loadData(wrData),
    .lastVal(SEC_LAST), .atLast(wrap.secLast), .val(seconds));

  cal_field #(.RST_VAL(8'd0), .WRAP_VAL(8'd0)) u_min (
    .clk, .rstN, .binMode, .inc(strobe.incMin), .load(ld[FLD_MIN]), .loadData(wrData),
    .lastVal(MIN_LAST), .atLast(wrap.minLast), .val(minutes));

  cal_field #(.RST_VAL(8'd0), .WRAP_VAL(8'd0)) u_hour (
    .clk, .rstN, .binMode, .inc(strobe.incHour), .load(ld[FLD_HOUR]), .loadData(wrData),
    .lastVal(HOUR_LAST), .atLast(wrap.hourLast), .val(hours));

  cal_field #(.RST_VAL(RST_WDAY), .WRAP_VAL(8'd1)) u_wday (
    .clk, .rstN, .binMode, .inc(strobe.incDay), .load(ld[FLD_WDAY]), .loadData(wrData),
    .lastVal(WDAY_LAST), .atLast(wdayLast), .val(weekDay));

  cal_field #(.RST_VAL(RST_MDAY), .WRAP_VAL(8'd1)) u_mday (
    .clk, .rstN, .binMode, .inc(strobe.incDay), .load(ld[FLD_MDAY]), .loadData(wrData),
    .lastVal(daysNow), .atLast(wrap.mdayLast), .val(monthDay));

  cal_field #(.RST_VAL(RST_MONTH), .WRAP_VAL(8'd1)) u_month (
    .clk, .rstN, .binMode, .inc(strobe.incMonth), .load(ld[FLD_MONTH]), .loadData(wrData),
    .lastVal(MONTH_LAST), .atLast(wrap.monthLast), .val(month));

  cal_field #(.RST_VAL(8'd0), .WRAP_VAL(8'd0)) u_year (
    .clk, .rstN, .binMode, .inc(strobe.incYear), .load(ld[FLD_YEAR]), .loadData(wrData),
    .lastVal(YEAR_LAST), .atLast(yearLast), .val(year));

  // day-of-week and year wraps end the carry chain; no consumer
  logic unusedLast;
  assign unusedLast = wdayLast ^ yearLast;
endmodule

// File: rtl/calendar_clock.sv
module calendar_clock
  import cal_pkg::*;
#(
  // reset date values must be below 10 so both encodings agree
  parameter logic [FIELD_W-1:0] RST_WDAY  = 8'd7,
  parameter logic [FIELD_W-1:0] RST_MDAY  = 8'd1,
  parameter logic [FIELD_W-1:0] RST_MONTH = 8'd1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               inhibit,
  input  logic               binMode,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [FIELD_W-1:0] wrData,
  output logic [FIELD_W-1:0] seconds,
  output logic [FIELD_W-1:0] minutes,
  output logic [FIELD_W-1:0] hours,
  output logic [FIELD_W-1:0] weekDay,
  output logic [FIELD_W-1:0] monthDay,
  output logic [FIELD_W-1:0] month,
  output logic [FIELD_W-1:0] year,
  output logic               secCarry
);
  calStrobe_t strobe;
  calWrap_t   wrap;

  cal_ctrl u_ctrl (
    .clk, .rstN, .tick, .inhibit, .wrEn, .wrSel, .wrap, .strobe, .secCarry);

  cal_datapath #(.RST_WDAY(RST_WDAY), .RST_MDAY(RST_MDAY), .RST_MONTH(RST_MONTH)) u_dp (
    .clk, .rstN, .binMode, .strobe, .wrData, .wrap,
    .seconds, .minutes, .hours, .weekDay, .monthDay, .month, .year);
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       inhibit,
  input logic       binMode,
  input logic       wrEn,
  input logic [2:0] wrSel,
  input logic [7:0] wrData,
  input logic [7:0] seconds,
  input logic [7:0] minutes,
  input logic [7:0] hours,
  input logic [7:0] weekDay,
  input logic [7:0] monthDay,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic       secCarry
);
  assert_inhibit_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inhibit && !wrEn) |=> $stable({seconds, minutes, hours, weekDay, monthDay, month, year}));

  assert_carry_rollover_R2: assert property (@(posedge clk) disable iff (!rstN)
    secCarry |-> (seconds == 8'd0 && $past(seconds) == (binMode ? 8'd59 : 8'h59)));

  assert_bcd_digits_R2: assert property (@(posedge clk) disable iff (!rstN)
    !binMode |-> (seconds[3:0] <= 4'd9 && minutes[3:0] <= 4'd9 && hours[3:0] <= 4'd9));

  assert_hour_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    hours <= (binMode ? 8'd23 : 8'h23));

  assert_wday_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (weekDay >= 8'd1 && weekDay <= 8'd7));

  assert_month_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (month >= 8'd1 && month <= (binMode ? 8'd12 : 8'h12)));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd0) |=> seconds == $past(wrData));

  assert_tick_dropped_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && tick && wrSel != 3'd0) |=> $stable(seconds));
endmodule

bind calendar_clock cal_clock_checker u_chk (.*);

// File: tb/calendar_clock_bench.sv
module calendar_clock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0, inhibit = 1'b0, binMode = 1'b0, wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] seconds, minutes, hours, weekDay, monthDay, month, year;
  logic       secCarry;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  calendar_clock u_calendar_clock (.*);

  function automatic logic [7:0] enc(input int v);
    return binMode ? 8'(v) : {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doTick();
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr(input int sel, input logic [7:0] d, input logic withTick);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = d; tick = withTick;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic setAll(input int y, input int mo, input int d, input int wd,
                        input int h, input int mi, input int s);
    wr(6, enc(y), 1'b0); wr(5, enc(mo), 1'b0); wr(4, enc(d), 1'b0);
    wr(3, enc(wd), 1'b0); wr(2, enc(h), 1'b0); wr(1, enc(mi), 1'b0);
    wr(0, enc(s), 1'b0);
  endtask

  task automatic doReset(input logic mode);
    rstN = 1'b0; binMode = mode;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runMode(input logic mode);
    string tag;
    doReset(mode);
    // R1 reset state
    chk("R1 sec", seconds, 8'd0);  chk("R1 min", minutes, 8'd0);
    chk("R1 hour", hours, 8'd0);   chk("R1 wday", weekDay, 8'd7);
    chk("R1 mday", monthDay, 8'd1); chk("R1 month", month, 8'd1);
    chk("R1 year", year, 8'd0);    chk("R1 carry", {7'd0, secCarry}, 8'd0);
    // R2 R3 R10 sweep of the first hour and a bit
    tag = mode ? "R10" : "R2";
    for (int k = 1; k <= 3700; k++) begin
      doTick();
      chk(tag, seconds, enc(k % 60));
      chk("R2 carry", {7'd0, secCarry}, {7'd0, (k % 60) == 0});
      chk("R3 min", minutes, enc((k / 60) % 60));
      chk("R3 hour", hours, enc(k / 3600));
    end
    // R3 R4 midnight
    setAll(5, 3, 10, 7, 23, 59, 59);
    doTick();
    chk("R3 hour wrap", hours, enc(0)); chk("R3 min wrap", minutes, enc(0));
    chk("R4 wday wrap", weekDay, enc(1)); chk("R5 mday step", monthDay, enc(11));
    // R5 R6 R7 calendar
    foreach (yrs[i]) begin
      for (int m = 1; m <= 12; m++) begin
        int y = yrs[i];
        int wd = m % 7 + 1;
        setAll(y, m, dim(m, y), wd, 23, 59, 59);
        doTick();
        chk(m == 2 ? "R6 last day" : "R5 last day", monthDay, enc(1));
        chk("R7 month", month, enc(m % 12 + 1));
        chk("R7 year", year, enc(m == 12 ? (y + 1) % 100 : y));
        chk("R4 wday", weekDay, enc(wd == 7 ? 1 : wd + 1));
        setAll(y, m, 28, wd, 23, 59, 59);
        doTick();
        chk(m == 2 ? "R6 day 28" : "R5 day 28", monthDay, enc(dim(m, y) > 28 ? 29 : 1));
      end
    end
    // R8 inhibit
    setAll(20, 6, 15, 3, 12, 30, 45);
    inhibit = 1'b1;
    repeat (5) doTick();
    chk("R8 sec", seconds, enc(45)); chk("R8 min", minutes, enc(30));
    wr(0, enc(10), 1'b0);
    chk("R9 write under inhibit", seconds, enc(10));
    inhibit = 1'b0;
    // R9 write wins over tick
    wr(0, enc(30), 1'b1);
    chk("R9 write priority", seconds, enc(30));
    wr(1, enc(5), 1'b1);
    chk("R9 tick dropped", seconds, enc(30));
    chk("R9 min load", minutes, enc(5));
    // R11 select 7
    wr(7, 8'h05, 1'b0);
    chk("R11 sec", seconds, enc(30)); chk("R11 min", minutes, enc(5));
    chk("R11 hour", hours, enc(12));  chk("R11 wday", weekDay, enc(3));
    chk("R11 mday", monthDay, enc(15)); chk("R11 month", month, enc(6));
    chk("R11 year", year, enc(20));
  endtask

  int yrs[5] = '{0, 1, 48, 50, 99};

  initial begin
    runMode(1'b0);
    runMode(1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule